// File: doc/BRIEF.md
# Configurable UART Transmit Engine

This block is the transmit half of a UART. It takes bytes from a byte-wide FIFO read port and sends them as serial characters on a TX line that idles high. A one-cycle clock-enable pulse from an external baud generator sets the bit period, so one bit lasts from one tick to the next. A character-format input selects the data width (7, 8 or 9 bits), the parity mode and the number of stop bits. The block copies this format when it fetches a character, so it can be reprogrammed between characters.

Nine-bit characters are built from two FIFO bytes read one after the other. A break input holds the line low for as long as it is nonzero. Two pause inputs gate the start of new characters: a level from XON/XOFF tracking and a clear-to-send level. A character that is already on the line always finishes. A busy flag and a final-stop-bit pulse let a transceiver direction controller follow the traffic.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset and between characters, txd is 1, busy is 0 and fifo_rd is 0.
- R2: A character is sent as one start bit (0), then the data bits least significant first, then the parity bit when enabled, then the stop bits (1). Each bit lasts exactly one tick period.
- R3: fmt[3:0] selects the data width. 4'b0111 gives 7 bits (FIFO bit 7 is not sent), 4'b1000 gives 8 bits and 4'b1001 gives 9 bits. Every other code gives 8 bits.
- R4: fmt[6:4] selects parity for 7 and 8 bit widths. 3'b000 means no parity bit. 3'b001 means odd: the data bits plus the parity bit hold an odd number of ones. 3'b010 means even. 3'b011 means the parity bit is always 1, and 3'b100 means it is always 0. Codes 3'b101 to 3'b111 mean no parity bit.
- R5: fmt[7] = 0 sends one stop bit and fmt[7] = 1 sends two.
- R6: In 9-bit mode the first FIFO byte supplies data bits 7..0 and bit 0 of the second FIFO byte supplies data bit 8. No parity bit is sent, whatever fmt[6:4] holds.
- R7: fifo_rd pulses once per FIFO byte, and only while fifo_empty is 0. A new character is fetched only when the engine is idle.
- R8: The format is captured when a character is fetched. Changing fmt while that character is being sent does not change it.
- R9: A nonzero brk drives txd low from the clock after the engine is idle. A character in progress finishes first. No byte is fetched while brk is nonzero. The line goes high again one clock after brk returns to zero.
- R10: While sw_pause is 1 or cts is 0, no new character starts and the FIFO is not read. A character already in progress completes. Sending resumes when both are released.
- R11: last_stop is 1 only during the tick cycle that ends the final stop bit, once per character.
- R12: busy is 1 from the fetch of a character through the end of its final stop bit. It is 0 while idle or in break.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-period clock enable from the baud generator |
| fmt | input | 8 | Character format: width [3:0], parity [6:4], stop bits [7] |
| brk | input | BRK_W | Break control, nonzero forces a break |
| sw_pause | input | 1 | 1 = transmission paused by a received XOFF |
| cts | input | 1 | 1 = remote side is clear to receive |
| fifo_empty | input | 1 | TX FIFO has no data |
| fifo_data | input | 8 | Head byte of the TX FIFO (first-word fall-through) |
| fifo_rd | output | 1 | Pops the head byte of the TX FIFO |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A character is being fetched or sent |
| last_stop | output | 1 | Pulse marking the end of the final stop bit |

## Verification
A fetch occurs on the first clock edge at which the engine is idle, the FIFO is not empty and neither pause nor break is active. The start bit appears on the line at the next tick edge, and every later bit changes only at a tick edge. The bench therefore samples txd, busy and last_stop at the falling clock edge of each tick cycle, which is the last moment of the bit then on the line. Break entry and exit take one clock, so those checks are made at the first falling edge after the event. Changes to format, break and clear-to-send inside a character are applied just after the start bit is seen, which keeps them clear of any fetch.

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int BRK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [7:0]       fmt,
  input  logic [BRK_W-1:0] brk,
  input  logic             sw_pause,
  input  logic             cts,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic             txd,
  output logic             busy,
  output logic             last_stop
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD2, S_READY, S_START, S_DATA, S_PAR, S_STOP, S_BREAK
  } state_t;

  state_t     st;
  logic [8:0] sr;
  logic [3:0] wid;
  logic [3:0] cnt;
  logic       par_en;
  logic       par_bit;
  logic       two_stop;

  logic [3:0] w_new;
  logic [7:0] d_eff;
  logic       ones_odd;
  logic       p_en_new;
  logic       p_bit_new;

  assign w_new    = (fmt[3:0] == 4'b0111) ? 4'd7 :
                    (fmt[3:0] == 4'b1001) ? 4'd9 : 4'd8;
  assign d_eff    = (w_new == 4'd7) ? {1'b0, fifo_data[6:0]} : fifo_data;
  assign ones_odd = ^d_eff;

  always_comb begin
    p_en_new  = 1'b0;
    p_bit_new = 1'b0;
    case (fmt[6:4])
      3'b001:  begin p_en_new = 1'b1; p_bit_new = ~ones_odd; end
      3'b010:  begin p_en_new = 1'b1; p_bit_new = ones_odd;  end
      3'b011:  begin p_en_new = 1'b1; p_bit_new = 1'b1;      end
      3'b100:  begin p_en_new = 1'b1; p_bit_new = 1'b0;      end
      default: begin p_en_new = 1'b0; p_bit_new = 1'b0;      end
    endcase
    if (w_new == 4'd9) p_en_new = 1'b0;
  end

  logic brk_on, may_go, fetch1, fetch2, stop_end;

  assign brk_on    = (brk != '0);
  assign may_go    = !brk_on && !sw_pause && cts;
  assign fetch1    = (st == S_IDLE) && may_go && !fifo_empty;
  assign fetch2    = (st == S_LOAD2) && !fifo_empty;
  assign fifo_rd   = fetch1 || fetch2;
  assign stop_end  = (st == S_STOP) && (!two_stop || cnt[0]);
  assign last_stop = tick && stop_end;
  assign busy      = (st != S_IDLE) && (st != S_BREAK);

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = sr[0];
      S_PAR:   txd = par_bit;
      S_BREAK: txd = 1'b0;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sr       <= '0;
      wid      <= 4'd8;
      cnt      <= '0;
      par_en   <= 1'b0;
      par_bit  <= 1'b0;
      two_stop <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (brk_on) st <= S_BREAK;
          else if (fetch1) begin
            sr       <= {1'b0, fifo_data};
            wid      <= w_new;
            par_en   <= p_en_new;
            par_bit  <= p_bit_new;
            two_stop <= fmt[7];
            st       <= (w_new == 4'd9) ? S_LOAD2 : S_READY;
          end
        S_LOAD2:
          if (fetch2) begin
            sr[8] <= fifo_data[0];
            st    <= S_READY;
          end
        S_READY:
          if (tick) st <= S_START;
        S_START:
          if (tick) begin
            st  <= S_DATA;
            cnt <= '0;
          end
        S_DATA:
          if (tick) begin
            if (cnt == wid - 4'd1) begin
              cnt <= '0;
              st  <= par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 4'd1;
              sr  <= sr >> 1;
            end
          end
        S_PAR:
          if (tick) st <= S_STOP;
        S_STOP:
          if (tick) begin
            if (stop_end) st <= S_IDLE;
            else cnt <= cnt + 4'd1;
          end
        S_BREAK:
          if (!brk_on) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk #(
  parameter int BRK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [BRK_W-1:0] brk,
  input logic             sw_pause,
  input logic             cts,
  input logic             fifo_empty,
  input logic             fifo_rd,
  input logic             txd,
  input logic             busy,
  input logic             last_stop
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txd);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(txd));

  p_pop_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  p_pop_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !busy) |=> busy);

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((brk != '0) && !busy) |=> !txd);

  p_break_nopop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((brk != '0) && !busy) |-> !fifo_rd);

  p_pause_nopop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (sw_pause || !cts)) |-> !fifo_rd);

  p_last_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_stop |-> (tick && txd && busy));

  p_last_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_stop |=> !busy);

endmodule

bind uart_tx_engine uart_tx_engine_chk #(.BRK_W(BRK_W)) u_chk (.*);

// File: tb/sim_uart_tx_engine.sv
`timescale 1ns/1ps
module sim_uart_tx_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [7:0] fmt = 8'h08;
  logic [7:0] brk = 8'h00;
  logic       sw_pause = 1'b0;
  logic       cts = 1'b1;
  logic       fifo_empty;
  logic [7:0] fifo_data;
  logic       fifo_rd, txd, busy, last_stop;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  logic [1:0] tc;
  always @(posedge clk) begin
    if (!rst_n) begin tc <= 2'd0; tick <= 1'b0; end
    else begin tc <= tc + 2'd1; tick <= (tc == 2'd3); end
  end

  logic [7:0] fq [16];
  int head = 0;
  int tail = 0;
  assign fifo_empty = (head == tail);
  assign fifo_data  = fq[head % 16];
  always @(posedge clk) if (fifo_rd) head <= head + 1;

  uart_tx_engine u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .brk(brk),
    .sw_pause(sw_pause), .cts(cts), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .txd(txd), .busy(busy),
    .last_stop(last_stop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fq[tail % 16] = b;
    tail++;
  endtask

  task automatic next_tick;
    do @(negedge clk); while (!tick);
  endtask

  function automatic int exp_frame(input logic [7:0] f, input logic [7:0] b0,
                                   input logic [7:0] b1, output logic [15:0] e);
    int w, n, ones;
    logic [8:0] d;
    w = (f[3:0] == 4'b0111) ? 7 : (f[3:0] == 4'b1001) ? 9 : 8;
    d = {b1[0], b0};
    e = '1;
    n = 0;
    ones = 0;
    e[n] = 1'b0; n++;
    for (int i = 0; i < w; i++) begin
      e[n] = d[i]; n++;
      if (d[i]) ones++;
    end
    if (w != 9) begin
      case (f[6:4])
        3'b001: begin e[n] = (ones % 2 == 0); n++; end
        3'b010: begin e[n] = (ones % 2 == 1); n++; end
        3'b011: begin e[n] = 1'b1; n++; end
        3'b100: begin e[n] = 1'b0; n++; end
        default: ;
      endcase
    end
    e[n] = 1'b1; n++;
    if (f[7]) begin e[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic grab(input int n, input logic [7:0] f_after, input logic [7:0] brk_after,
                      input logic cts_after, output logic [15:0] got,
                      output int ls_bad, output int busy_bad);
    logic seen;
    seen = 1'b0;
    got = '1;
    ls_bad = 0;
    busy_bad = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (tick && !txd) seen = 1'b1;
    end
    if (!seen) begin
      ls_bad = 99;
      return;
    end
    got[0] = 1'b0;
    if (last_stop) ls_bad++;
    if (!busy) busy_bad++;
    fmt = f_after;
    brk = brk_after;
    cts = cts_after;
    for (int i = 1; i < n; i++) begin
      next_tick();
      got[i] = txd;
      if (last_stop != (i == n - 1)) ls_bad++;
      if (!busy) busy_bad++;
    end
  endtask

  task automatic run_frame(input logic [7:0] f, input logic [7:0] b0,
                           input logic [7:0] b1, input string req);
    logic [15:0] e, got, m;
    int n, h0, lsb, bb;
    n = exp_frame(f, b0, b1, e);
    m = 16'((1 << n) - 1);
    @(negedge clk);
    fmt = f;
    h0 = head;
    push(b0);
    if (f[3:0] == 4'b1001) push(b1);
    grab(n, f, 8'h00, 1'b1, got, lsb, bb);
    chk(req, "frame bits", int'(got & m), int'(e & m));
    chk("R11", "last_stop placement errors", lsb, 0);
    chk("R12", "busy low inside frame", bb, 0);
    next_tick();
    chk("R1", "line idle after frame", {txd, busy}, 2);
    chk("R7", "bytes popped", head - h0, (f[3:0] == 4'b1001) ? 2 : 1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "reset txd/busy/fifo_rd", {txd, busy, fifo_rd}, 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", {txd, busy, fifo_rd}, 4);
  endtask

  task automatic t_formats;
    run_frame(8'h08, 8'hA5, 8'h00, "R2");
    run_frame(8'h27, 8'hD3, 8'h00, "R3");
    run_frame(8'h98, 8'h0F, 8'h00, "R5");
    run_frame(8'h18, 8'h07, 8'h00, "R4");
    run_frame(8'h38, 8'h00, 8'h00, "R4");
    run_frame(8'h48, 8'hFF, 8'h00, "R4");
    run_frame(8'h58, 8'h6E, 8'h00, "R4");
    run_frame(8'h00, 8'h96, 8'h00, "R3");
    run_frame(8'h1A, 8'h01, 8'h00, "R3");
    run_frame(8'hB7, 8'h2A, 8'h00, "R5");
  endtask

  task automatic t_nine;
    run_frame(8'h29, 8'h3C, 8'h01, "R6");
    run_frame(8'h29, 8'h81, 8'hFE, "R6");
    run_frame(8'hB9, 8'h55, 8'h03, "R6");
  endtask

  task automatic t_latch;
    logic [15:0] e, got, m;
    int n, h0, lsb, bb;
    n = exp_frame(8'h08, 8'h5A, 8'h00, e);
    m = 16'((1 << n) - 1);
    @(negedge clk);
    fmt = 8'h08;
    h0 = head;
    push(8'h5A);
    grab(n, 8'hA9, 8'h00, 1'b1, got, lsb, bb);
    chk("R8", "frame after mid-character fmt change", int'(got & m), int'(e & m));
    chk("R8", "last_stop with changed fmt", lsb, 0);
    next_tick();
    chk("R8", "idle after latched frame", {txd, busy}, 2);
    fmt = 8'h08;
  endtask

  task automatic t_break;
    logic [15:0] e, got, m;
    int n, h0, lsb, bb, lows;
    n = exp_frame(8'h08, 8'hC3, 8'h00, e);
    m = 16'((1 << n) - 1);
    @(negedge clk);
    fmt = 8'h08;
    h0 = head;
    push(8'hC3);
    push(8'h3C);
    grab(n, 8'h08, 8'h01, 1'b1, got, lsb, bb);
    chk("R9", "character completes before break", int'(got & m), int'(e & m));
    lows = 0;
    for (int i = 0; i < 5; i++) begin
      next_tick();
      if (!txd && !busy) lows++;
    end
    chk("R9", "tick periods held low in break", lows, 5);
    chk("R9", "no fetch during break", head - h0, 1);
    @(negedge clk);
    brk = 8'h00;
    @(negedge clk);
    chk("R9", "line high after break cleared", txd, 1);
    n = exp_frame(8'h08, 8'h3C, 8'h00, e);
    m = 16'((1 << n) - 1);
    grab(n, 8'h08, 8'h00, 1'b1, got, lsb, bb);
    chk("R9", "queued byte after break", int'(got & m), int'(e & m));
    next_tick();
    chk("R9", "idle after queued byte", {txd, busy}, 2);
    @(negedge clk);
    brk = 8'h80;
    @(negedge clk);
    chk("R9", "idle break one clock later", {txd, busy}, 0);
    brk = 8'h00;
    @(negedge clk);
    chk("R9", "idle break release", {txd, busy}, 2);
  endtask

  task automatic t_pause;
    logic [15:0] e, got, m;
    int n, h0, lsb, bb, highs;
    @(negedge clk);
    fmt = 8'h08;
    sw_pause = 1'b1;
    h0 = head;
    push(8'h11);
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      next_tick();
      if (txd && !busy) highs++;
    end
    chk("R10", "line idle while paused", highs, 6);
    chk("R10", "no pop while paused", head - h0, 0);
    sw_pause = 1'b0;
    n = exp_frame(8'h08, 8'h11, 8'h00, e);
    m = 16'((1 << n) - 1);
    grab(n, 8'h08, 8'h00, 1'b1, got, lsb, bb);
    chk("R10", "frame after resume", int'(got & m), int'(e & m));
    next_tick();
    @(negedge clk);
    h0 = head;
    push(8'hE7);
    push(8'h18);
    n = exp_frame(8'h08, 8'hE7, 8'h00, e);
    m = 16'((1 << n) - 1);
    grab(n, 8'h08, 8'h00, 1'b0, got, lsb, bb);
    chk("R10", "frame completes after cts drop", int'(got & m), int'(e & m));
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      next_tick();
      if (txd && !busy) highs++;
    end
    chk("R10", "line idle while cts low", highs, 6);
    chk("R10", "second byte held while cts low", head - h0, 1);
    cts = 1'b1;
    n = exp_frame(8'h08, 8'h18, 8'h00, e);
    m = 16'((1 << n) - 1);
    grab(n, 8'h08, 8'h00, 1'b1, got, lsb, bb);
    chk("R10", "frame after cts return", int'(got & m), int'(e & m));
    next_tick();
    chk("R10", "idle after cts sequence", {txd, busy}, 2);
  endtask

  initial begin
    t_reset();
    t_formats();
    t_nine();
    t_latch();
    t_break();
    t_pause();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule